// File: doc/BRIEF.md
# Flash Status and Write-Protect Unit

This block keeps the two status bytes of a serial NOR flash controller and decides whether each memory-write request may proceed. A serial front end, which has already shifted in and decoded the command byte, hands the block single-cycle strobes: set write-enable, clear write-enable, load status byte 0, load status byte 1, program, erase, start auto-increment programming and leave auto-increment programming. The front end also supplies the data byte for the status loads and the target address for program and erase. The array sequencer returns a one-cycle completion pulse when the internal write finishes.

The block answers each program, erase or auto-increment start with a registered accept or reject pulse. An accepted request raises the busy flag, which stays up until the completion pulse arrives. While busy is up, every strobe is refused. Protection has three layers. A two-bit level fences off none, the upper quarter, the upper half or all of the array. A lock bit freezes that level. Two separate bits lock the highest and the lowest 4 KiB sector. With the default parameters the array holds 256 KiB and uses an 18-bit address.

Top module: `nvm_status_guard`

## Requirements
- R1: After a synchronous reset, status0 reads 0x0C (both level bits set), status1 reads 0x00, and busy, wr_accept and wr_reject are 0.
- R2: The write-enable strobe sets status0 bit 1 (write latch). The write-disable strobe clears it. Each takes effect at the clock edge that samples the strobe.
- R3: The status-0 load is acted on only while the write latch is 1. It copies wr_data bit 7 into the lock bit (status0 bit 7) and wr_data bits 3:2 into the level bits (status0 bits 3:2), and clears the write latch. wr_data bits 6:4 and 1:0 have no effect. Without the write latch, the load changes nothing.
- R4: If the lock bit is 1 before a status-0 load, the level bits keep their value, but the lock bit itself is still loaded.
- R5: The status-1 load needs the write latch and clears it. It copies wr_data bit 2 into the top-sector lock (status1 bit 2) and wr_data bit 3 into the bottom-sector lock (status1 bit 3). Every other status1 bit reads 0.
- R6: Program, erase and auto-increment start are accepted only when the write latch is 1, busy is 0 and the address is unprotected. The clock edge that samples the strobe raises wr_accept for one cycle and sets busy (status0 bit 0). Any other outcome raises wr_reject for one cycle instead.
- R7: Level 00 protects nothing. Level 01 protects addresses whose top two bits are 11. Level 10 protects addresses whose top bit is 1. Level 11 protects every address.
- R8: When the top-sector lock is 1, addresses whose bits above bit 11 are all ones are protected. When the bottom-sector lock is 1, addresses whose bits above bit 11 are all zeros are protected.
- R9: While busy is 1, every strobe is refused and leaves both status bytes unchanged. The completion pulse clears busy, and outside auto-increment mode it also clears the write latch, at the same clock edge.
- R10: An accepted auto-increment start sets status0 bit 6. In that mode only program and leave-mode strobes are acted on. The completion pulse clears busy but keeps the write latch. Leave-mode, while idle, clears bit 6 and the write latch.
- R11: status0 bits 5:4 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wren | input | 1 | Set write-enable latch strobe |
| cmd_wrdi | input | 1 | Clear write-enable latch strobe |
| cmd_wrsr | input | 1 | Load status byte 0 strobe |
| cmd_wrsr1 | input | 1 | Load status byte 1 strobe |
| cmd_prog | input | 1 | Program request strobe |
| cmd_erase | input | 1 | Erase request strobe |
| cmd_aai_start | input | 1 | Start auto-increment programming strobe |
| cmd_aai_exit | input | 1 | Leave auto-increment programming strobe |
| wr_data | input | 8 | Data byte for status loads |
| target_addr | input | ADDR_W | Target address of a program or erase |
| op_done | input | 1 | Completion pulse from the array sequencer |
| status0 | output | 8 | Status byte 0 |
| status1 | output | 8 | Status byte 1 |
| busy | output | 1 | Internal write in progress |
| wr_accept | output | 1 | Memory-write request accepted (one cycle) |
| wr_reject | output | 1 | Memory-write request refused (one cycle) |

## Verification
Memory-write requests are sent at addresses that sit on each side of every protection boundary: the quarter and half fences and the first and last 4 KiB sectors. An off-by-one in the level decode or the sector compare therefore turns an accept into a reject, or the reverse. Status loads are sent with and without the write latch, with the lock bit set and clear, and with the reserved data bits set. This separates gating errors from field-mapping errors. Strobes sent while busy and while in auto-increment mode show whether refusal and latch retention follow the mode or the command kind.

// File: rtl/nvm_sg_pkg.sv
package nvm_sg_pkg;

  // status byte 0, bit 7 down to bit 0
  typedef struct packed {
    logic       lock;
    logic       aai;
    logic [1:0] rsv;
    logic [1:0] lvl;
    logic       wel;
    logic       busy;
  } sr0_t;

  typedef enum logic [1:0] {
    LVL_NONE = 2'b00,
    LVL_QTR  = 2'b01,
    LVL_HALF = 2'b10,
    LVL_ALL  = 2'b11
  } lvl_e;

  typedef struct packed {
    logic wren;
    logic wrdi;
    logic wrsr;
    logic wrsr1;
    logic prog;
    logic erase;
    logic aai_start;
    logic aai_exit;
  } cmd_t;

  typedef struct packed {
    logic set_wel;
    logic clr_wel;
    logic load_sr0;
    logic load_sr1;
    logic mem_ok;
    logic mem_rej;
    logic enter_aai;
    logic leave_aai;
  } act_t;

endpackage

// File: rtl/sg_region_check.sv
module sg_region_check
  import nvm_sg_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int SECT_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        lvl,
  input  logic              top_lock,
  input  logic              bot_lock,
  output logic              hit
);
  localparam int SEC_IDX_W = ADDR_W - SECT_W;

  logic [SEC_IDX_W-1:0] sec_idx;
  logic [1:0]           top2;
  logic                 lvl_hit;
  logic                 top_hit;
  logic                 bot_hit;
  logic [SECT_W-1:0]    unused_offset;

  assign sec_idx       = addr[ADDR_W-1:SECT_W];
  assign top2          = addr[ADDR_W-1 -: 2];
  assign unused_offset = addr[SECT_W-1:0];

  always_comb begin
    unique case (lvl_e'(lvl))
      LVL_NONE: lvl_hit = 1'b0;
      LVL_QTR:  lvl_hit = (top2 == 2'b11);
      LVL_HALF: lvl_hit = top2[1];
      LVL_ALL:  lvl_hit = 1'b1;
      default:  lvl_hit = 1'b1;
    endcase
  end

  assign top_hit = top_lock && (sec_idx == {SEC_IDX_W{1'b1}});
  assign bot_hit = bot_lock && (sec_idx == {SEC_IDX_W{1'b0}});
  assign hit     = lvl_hit || top_hit || bot_hit;

endmodule

// File: rtl/sg_cmd_gate.sv
module sg_cmd_gate
  import nvm_sg_pkg::*;
(
  input  cmd_t cmd,
  input  logic busy,
  input  logic wel,
  input  logic aai,
  input  logic prot_hit,
  output act_t act
);
  logic idle;
  logic plain;
  logic mem_req;
  logic kind_ok;

  assign idle    = !busy;
  assign plain   = idle && !aai;
  assign mem_req = cmd.prog || cmd.erase || cmd.aai_start;

  // in auto-increment mode only a program strobe continues the sequence
  assign kind_ok = aai ? (cmd.prog && !cmd.erase && !cmd.aai_start) : 1'b1;

  always_comb begin
    act           = '0;
    act.set_wel   = cmd.wren && plain;
    act.clr_wel   = cmd.wrdi && plain;
    act.load_sr0  = cmd.wrsr && plain && wel;
    act.load_sr1  = cmd.wrsr1 && plain && wel;
    act.mem_ok    = mem_req && idle && wel && kind_ok && !prot_hit;
    act.mem_rej   = mem_req && !act.mem_ok;
    act.enter_aai = act.mem_ok && cmd.aai_start && !aai;
    act.leave_aai = cmd.aai_exit && idle && aai;
  end

endmodule

// File: rtl/sg_status_regs.sv
module sg_status_regs
  import nvm_sg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  act_t       act,
  input  logic [7:0] wr_data,
  input  logic       op_done,
  output sr0_t       sr0,
  output logic       top_lock,
  output logic       bot_lock,
  output logic       acc_q,
  output logic       rej_q
);
  logic unused_data;
  assign unused_data = ^{wr_data[6:4], wr_data[1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      sr0      <= '{lock: 1'b0, aai: 1'b0, rsv: 2'b00, lvl: 2'b11, wel: 1'b0, busy: 1'b0};
      top_lock <= 1'b0;
      bot_lock <= 1'b0;
      acc_q    <= 1'b0;
      rej_q    <= 1'b0;
    end else begin
      acc_q <= act.mem_ok;
      rej_q <= act.mem_rej;

      if (sr0.busy && op_done) begin
        sr0.busy <= 1'b0;
        if (!sr0.aai) sr0.wel <= 1'b0;
      end
      if (act.mem_ok)    sr0.busy <= 1'b1;
      if (act.enter_aai) sr0.aai  <= 1'b1;

      if (act.set_wel) sr0.wel <= 1'b1;
      if (act.clr_wel) sr0.wel <= 1'b0;

      if (act.load_sr0) begin
        sr0.lock <= wr_data[7];
        if (!sr0.lock) sr0.lvl <= wr_data[3:2];
        sr0.wel  <= 1'b0;
      end

      if (act.load_sr1) begin
        top_lock <= wr_data[2];
        bot_lock <= wr_data[3];
        sr0.wel  <= 1'b0;
      end

      if (act.leave_aai) begin
        sr0.aai <= 1'b0;
        sr0.wel <= 1'b0;
      end

      sr0.rsv <= 2'b00;
    end
  end

endmodule

// File: rtl/nvm_status_guard.sv
module nvm_status_guard
  import nvm_sg_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int SECT_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wren,
  input  logic              cmd_wrdi,
  input  logic              cmd_wrsr,
  input  logic              cmd_wrsr1,
  input  logic              cmd_prog,
  input  logic              cmd_erase,
  input  logic              cmd_aai_start,
  input  logic              cmd_aai_exit,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] target_addr,
  input  logic              op_done,
  output logic [7:0]        status0,
  output logic [7:0]        status1,
  output logic              busy,
  output logic              wr_accept,
  output logic              wr_reject
);
  cmd_t cmd;
  act_t act;
  sr0_t sr0;
  logic top_lock;
  logic bot_lock;
  logic prot_hit;

  assign cmd = '{wren: cmd_wren, wrdi: cmd_wrdi, wrsr: cmd_wrsr, wrsr1: cmd_wrsr1,
                 prog: cmd_prog, erase: cmd_erase, aai_start: cmd_aai_start,
                 aai_exit: cmd_aai_exit};

  sg_region_check #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_region (
    .addr     (target_addr),
    .lvl      (sr0.lvl),
    .top_lock (top_lock),
    .bot_lock (bot_lock),
    .hit      (prot_hit)
  );

  sg_cmd_gate u_gate (
    .cmd      (cmd),
    .busy     (sr0.busy),
    .wel      (sr0.wel),
    .aai      (sr0.aai),
    .prot_hit (prot_hit),
    .act      (act)
  );

  sg_status_regs u_regs (
    .clk      (clk),
    .rst      (rst),
    .act      (act),
    .wr_data  (wr_data),
    .op_done  (op_done),
    .sr0      (sr0),
    .top_lock (top_lock),
    .bot_lock (bot_lock),
    .acc_q    (wr_accept),
    .rej_q    (wr_reject)
  );

  assign status0 = sr0;
  assign status1 = {4'b0000, bot_lock, top_lock, 2'b00};
  assign busy    = sr0.busy;

endmodule

// File: rtl/sg_checker.sv
module sg_checker #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_wren,
  input logic              cmd_wrdi,
  input logic              cmd_wrsr,
  input logic              cmd_wrsr1,
  input logic              cmd_prog,
  input logic              cmd_erase,
  input logic              cmd_aai_start,
  input logic              cmd_aai_exit,
  input logic [7:0]        wr_data,
  input logic [ADDR_W-1:0] target_addr,
  input logic              op_done,
  input logic [7:0]        status0,
  input logic [7:0]        status1,
  input logic              busy,
  input logic              wr_accept,
  input logic              wr_reject
);
  // R11
  rsv0_zero_chk: assert property (@(posedge clk) disable iff (rst)
    status0[5:4] == 2'b00);

  // R5
  rsv1_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (status1 & 8'hF3) == 8'h00);

  // R4
  lvl_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(status0[7])) |-> (status0[3:2] == $past(status0[3:2])));

  // R6
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> wr_accept);

  // R6
  accept_needs_wel_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_accept && !$past(rst)) |-> ($past(status0[1]) && !$past(busy)));

  // R6
  one_verdict_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_accept && wr_reject));

  // R9
  done_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && op_done) |=> !busy);

  // R9
  busy_bit_chk: assert property (@(posedge clk) disable iff (rst)
    status0[0] == busy);

  // R10
  aai_keeps_wel_chk: assert property (@(posedge clk) disable iff (rst)
    status0[6] |-> status0[1]);
endmodule

bind nvm_status_guard sg_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_nvm_status_guard.sv
module sim_nvm_status_guard;
  localparam int AW = 18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_wren = 0, cmd_wrdi = 0, cmd_wrsr = 0, cmd_wrsr1 = 0;
  logic cmd_prog = 0, cmd_erase = 0, cmd_aai_start = 0, cmd_aai_exit = 0;
  logic [7:0]    wr_data = '0;
  logic [AW-1:0] target_addr = '0;
  logic op_done = 0;
  logic [7:0] status0, status1;
  logic busy, wr_accept, wr_reject;

  int checks = 0;
  int fails  = 0;

  localparam int K_WREN = 0, K_WRDI = 1, K_WRSR = 2, K_WRSR1 = 3,
                 K_PROG = 4, K_ERASE = 5, K_AAIS = 6, K_AAIX = 7, K_DONE = 8;

  always #10 clk = ~clk;

  nvm_status_guard #(.ADDR_W(AW)) u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // drive one strobe for one cycle; outputs are sampled at the next falling edge
  task automatic pulse(input int k, input logic [7:0] d = 8'h00, input logic [AW-1:0] a = '0);
    @(negedge clk);
    wr_data = d; target_addr = a;
    case (k)
      K_WREN:  cmd_wren = 1;
      K_WRDI:  cmd_wrdi = 1;
      K_WRSR:  cmd_wrsr = 1;
      K_WRSR1: cmd_wrsr1 = 1;
      K_PROG:  cmd_prog = 1;
      K_ERASE: cmd_erase = 1;
      K_AAIS:  cmd_aai_start = 1;
      K_AAIX:  cmd_aai_exit = 1;
      default: op_done = 1;
    endcase
    @(negedge clk);
    {cmd_wren, cmd_wrdi, cmd_wrsr, cmd_wrsr1, cmd_prog, cmd_erase,
     cmd_aai_start, cmd_aai_exit, op_done} = '0;
  endtask

  task automatic set_sr0(input logic [7:0] d);
    pulse(K_WREN); pulse(K_WRSR, d);
  endtask

  task automatic set_sr1(input logic [7:0] d);
    pulse(K_WREN); pulse(K_WRSR1, d);
  endtask

  task automatic mem_op(input string req, input int k, input logic [AW-1:0] a, input bit ok);
    pulse(K_WREN);
    pulse(k, 8'h00, a);
    chk(req, {wr_accept, wr_reject}, ok ? 2'b10 : 2'b01);
    if (ok) pulse(K_DONE);
    else    pulse(K_WRDI);
    chk(req, busy, 0);
  endtask

  task automatic t_reset();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 status0", status0, 8'h0C);
    chk("R1 status1", status1, 8'h00);
    chk("R1 flags", {busy, wr_accept, wr_reject}, 3'b000);
    chk("R11 reserved", status0[5:4], 0);
  endtask

  task automatic t_wel();
    pulse(K_WREN);
    chk("R2 wren", status0, 8'h0E);
    pulse(K_WRDI);
    chk("R2 wrdi", status0, 8'h0C);
  endtask

  task automatic t_sr0_load();
    pulse(K_WRSR, 8'h00);
    chk("R3 no latch", status0, 8'h0C);
    set_sr0(8'h73);
    chk("R3 ignored bits", status0, 8'h00);
    set_sr0(8'h08);
    chk("R3 level load", status0, 8'h08);
    set_sr0(8'h00);
    chk("R3 level clear", status0, 8'h00);
  endtask

  task automatic t_lock();
    set_sr0(8'h80);
    chk("R4 lock set", status0, 8'h80);
    set_sr0(8'h8C);
    chk("R4 frozen", status0, 8'h80);
    set_sr0(8'h0C);
    chk("R4 unlock keeps level", status0, 8'h00);
    set_sr0(8'h04);
    chk("R4 writable again", status0, 8'h04);
    set_sr0(8'h00);
  endtask

  task automatic t_gate();
    pulse(K_PROG, 8'h00, 18'h00100);
    chk("R6 no latch reject", {wr_accept, wr_reject}, 2'b01);
    chk("R6 no latch idle", status0, 8'h00);
    pulse(K_WREN);
    pulse(K_PROG, 8'h00, 18'h00100);
    chk("R6 accept", {wr_accept, wr_reject}, 2'b10);
    chk("R6 busy set", status0, 8'h03);
    pulse(K_WRDI);
    chk("R9 wrdi refused", status0, 8'h03);
    pulse(K_ERASE, 8'h00, 18'h01000);
    chk("R9 erase refused", {wr_accept, wr_reject}, 2'b01);
    pulse(K_WRSR, 8'h0C);
    chk("R9 load refused", status0, 8'h03);
    pulse(K_WRSR1, 8'h0C);
    chk("R9 load1 refused", status1, 8'h00);
    pulse(K_DONE);
    chk("R9 done clears", status0, 8'h00);
    mem_op("R6 erase", K_ERASE, 18'h01000, 1);
  endtask

  task automatic t_levels();
    set_sr0(8'h04);
    mem_op("R7 qtr in", K_PROG, 18'h30000, 0);
    mem_op("R7 qtr out", K_PROG, 18'h2FFFF, 1);
    set_sr0(8'h08);
    mem_op("R7 half in", K_ERASE, 18'h20000, 0);
    mem_op("R7 half out", K_PROG, 18'h1FFFF, 1);
    set_sr0(8'h0C);
    mem_op("R7 all low", K_PROG, 18'h00000, 0);
    mem_op("R7 all high", K_PROG, 18'h3FFFF, 0);
    set_sr0(8'h00);
    mem_op("R7 none", K_PROG, 18'h3FFFF, 1);
  endtask

  task automatic t_sectors();
    pulse(K_WRSR1, 8'h0C);
    chk("R5 no latch", status1, 8'h00);
    set_sr1(8'h04);
    chk("R5 top lock", status1, 8'h04);
    chk("R5 latch cleared", status0, 8'h00);
    mem_op("R8 top in", K_PROG, 18'h3F000, 0);
    mem_op("R8 top edge", K_PROG, 18'h3EFFF, 1);
    mem_op("R8 low free", K_PROG, 18'h00000, 1);
    set_sr1(8'h08);
    chk("R5 bottom lock", status1, 8'h08);
    mem_op("R8 bottom in", K_ERASE, 18'h00FFF, 0);
    mem_op("R8 bottom edge", K_PROG, 18'h01000, 1);
    mem_op("R8 high free", K_PROG, 18'h3FFFF, 1);
    set_sr1(8'hF3);
    chk("R5 reserved", status1, 8'h00);
  endtask

  task automatic t_aai();
    pulse(K_WREN);
    pulse(K_AAIS, 8'h00, 18'h00100);
    chk("R10 start accept", {wr_accept, wr_reject}, 2'b10);
    chk("R10 mode busy", status0, 8'h43);
    pulse(K_DONE);
    chk("R10 latch kept", status0, 8'h42);
    pulse(K_WRDI);
    chk("R10 wrdi refused", status0, 8'h42);
    pulse(K_ERASE, 8'h00, 18'h02000);
    chk("R10 erase refused", {wr_accept, wr_reject}, 2'b01);
    pulse(K_PROG, 8'h00, 18'h00101);
    chk("R10 next word", status0, 8'h43);
    pulse(K_AAIX);
    chk("R10 exit while busy", status0, 8'h43);
    pulse(K_DONE);
    chk("R10 word done", status0, 8'h42);
    pulse(K_AAIX);
    chk("R10 exit", status0, 8'h00);
    pulse(K_AAIX);
    chk("R10 exit idle", status0, 8'h00);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_wel();
    t_sr0_load();
    t_lock();
    t_gate();
    t_levels();
    t_sectors();
    t_aai();
    t_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule